// File: doc/BRIEF.md
# Vertical Count-Down Divider

This block produces the field-rate vertical output pulse of a television sync processor. It counts half-line ticks from the line timing and restarts the count when a separated vertical sync arrives inside an acceptance window. When no sync arrives before the window closes, it restarts the count itself. The window is narrow around 625 half-lines for the 50 Hz standard and around 525 half-lines for the 60 Hz standard. A wide search window is used while the standard is unknown or when the search bit is set.

Mode bits choose how the standard is picked. The block can follow its own detection, fall back to a fixed standard while line sync is unlocked, be forced to 60 Hz, or keep the last detected standard. A status output reports the standard the block has recognised. In external-clamp mode the vertical pulse pin is released: the output enable goes low and the pulse is held low.

Top module: `vertical_countdown`

## Requirements
- R1: While reset is asserted, `vpulse` is 0, `vpulse_oe` is 1 and `std_det` is 2'b00 (unknown).
- R2: A field ends on a half-line tick. In the next cycle the count restarts at 0, and `vpulse` rises and stays high for exactly 6 half-line ticks.
- R3: A vertical sync is ignored when its tick would take the count (previous count plus one) outside the active window. No field ends and `vpulse` stays low.
- R4: If no sync is accepted, the field ends on the tick that takes the count to the upper edge of the active window, or past it.
- R5: The window bounds, inclusive, are 622..628 for 50 Hz, 522..528 for 60 Hz and 488..722 for search. When the selected standard is unknown or non-standard, the search window is used.
- R6: Each field end is classed as 50 Hz (sync accepted at a count of 622..628), 60 Hz (sync at 522..528) or non-standard (any other end, including a self-generated one). After 4 consecutive fields of the same class, `std_det` takes that class: 2'b01 for 50 Hz, 2'b10 for 60 Hz, 2'b11 for non-standard.
- R7: With `ff_mode` = 2'b00 the 60 Hz window is used while `line_locked` is 0. With `ff_mode` = 2'b11 the 50 Hz window is used while `line_locked` is 0. With `line_locked` = 1, both modes use the window of `std_det`.
- R8: With `ff_mode` = 2'b01 the 60 Hz window applies from the very next tick, whatever the detected standard and the current count.
- R9: With `ff_mode` = 2'b10, `std_det` is frozen and its window is used.
- R10: `search_en` = 1 selects the search window over every mode.
- R11: While `ext_clamp` is 1, `vpulse_oe` is 0 and `vpulse` is 0 in the same cycle. Counting goes on unchanged.
- R12: `vsync_in` has an effect only in cycles where `hl_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hl_tick | input | 1 | One-cycle strobe per half-line |
| vsync_in | input | 1 | Separated vertical sync, sampled on ticks |
| line_locked | input | 1 | Line oscillator is in lock |
| ff_mode | input | 2 | Field-frequency mode: 00 auto/60, 01 forced 60, 10 hold, 11 auto/50 |
| search_en | input | 1 | Force the wide search window |
| ext_clamp | input | 1 | External clamp mode: release the pulse pin |
| vpulse | output | 1 | Vertical output pulse |
| vpulse_oe | output | 1 | Output enable of the pulse pin (0 = high impedance) |
| std_det | output | 2 | Detected standard: 00 unknown, 01 50 Hz, 10 60 Hz, 11 non-standard |

## Verification
A wrong count or a wrong window shows at the ports as a vertical pulse that starts on the wrong tick, within one field of the fault. A pulse of the wrong width shows six ticks after the field start. A fault in the run counter of the standard tracker shows in `std_det` only at the fourth field end after it, so each detection scenario runs at least four fields and checks the status before and after the switch. A mode decode error moves the self-generated pulse to another window edge in the same field. This can be seen without any sync present.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
   typedef enum logic [1:0] {
      STD_NONE = 2'b00,
      STD_50   = 2'b01,
      STD_60   = 2'b10,
      STD_ODD  = 2'b11
   } vstd_e;

   typedef enum logic [1:0] {
      FF_AUTO60  = 2'b00,
      FF_FORCE60 = 2'b01,
      FF_HOLD    = 2'b10,
      FF_AUTO50  = 2'b11
   } ffmode_e;

   typedef enum logic [1:0] {
      WIN_SEARCH = 2'd0,
      WIN_50     = 2'd1,
      WIN_60     = 2'd2,
      WIN_SPARE  = 2'd3
   } win_e;
endpackage

// File: rtl/vcd_window_sel.sv
module vcd_window_sel
   import vcd_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int W50_LO = 622,
   parameter int W50_HI = 628,
   parameter int W60_LO = 522,
   parameter int W60_HI = 528,
   parameter int WSR_LO = 488,
   parameter int WSR_HI = 722
) (
   input  logic [1:0]       ff_mode,
   input  logic             line_locked,
   input  logic             search_en,
   input  vstd_e            std_det,
   output logic [CNT_W-1:0] win_lo,
   output logic [CNT_W-1:0] win_hi,
   output logic             hold
);
   localparam int N_SLOT = 4;

   logic [CNT_W-1:0] lo_tab [N_SLOT];
   logic [CNT_W-1:0] hi_tab [N_SLOT];
   win_e             from_std;
   win_e             sel;
   ffmode_e          mode;

   // bound table, one slot per window code; the spare code maps to search
   for (genvar g = 0; g < N_SLOT; g++) begin : g_tab
      localparam int LO = (g == 1) ? W50_LO : (g == 2) ? W60_LO : WSR_LO;
      localparam int HI = (g == 1) ? W50_HI : (g == 2) ? W60_HI : WSR_HI;
      assign lo_tab[g] = CNT_W'(LO);
      assign hi_tab[g] = CNT_W'(HI);
   end

   assign mode = ffmode_e'(ff_mode);

   always_comb begin
      case (std_det)
         STD_50:  from_std = WIN_50;
         STD_60:  from_std = WIN_60;
         default: from_std = WIN_SEARCH;
      endcase
   end

   always_comb begin
      case (mode)
         FF_FORCE60: sel = WIN_60;
         FF_AUTO60:  sel = line_locked ? from_std : WIN_60;
         FF_AUTO50:  sel = line_locked ? from_std : WIN_50;
         default:    sel = from_std;
      endcase
      if (search_en) sel = WIN_SEARCH;
   end

   assign win_lo = lo_tab[sel];
   assign win_hi = hi_tab[sel];
   assign hold   = (mode == FF_HOLD);
endmodule

// File: rtl/vcd_halfline_ctr.sv
module vcd_halfline_ctr #(
   parameter int CNT_W    = 10,
   parameter int PULSE_HL = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hl_tick,
   input  logic             vsync_in,
   input  logic [CNT_W-1:0] win_lo,
   input  logic [CNT_W-1:0] win_hi,
   output logic             field_end,
   output logic             sync_taken,
   output logic [CNT_W-1:0] end_cnt,
   output logic             pulse_raw
);
   localparam logic [CNT_W-1:0] PW = CNT_W'(PULSE_HL);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             run_q;
   logic             in_win;
   logic             timeout;

   assign cnt_nx     = cnt_q + CNT_W'(1);
   assign in_win     = (cnt_nx >= win_lo) && (cnt_nx <= win_hi);
   assign sync_taken = hl_tick && vsync_in && in_win;
   // a window that shrank below the running count closes at once
   assign timeout    = hl_tick && !sync_taken && (cnt_nx >= win_hi);
   assign field_end  = sync_taken || timeout;
   assign end_cnt    = cnt_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (field_end) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (hl_tick) begin
         cnt_q <= cnt_nx;
      end
   end

   assign pulse_raw = run_q && (cnt_q < PW);
endmodule

// File: rtl/vcd_std_tracker.sv
module vcd_std_tracker
   import vcd_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int W50_LO = 622,
   parameter int W50_HI = 628,
   parameter int W60_LO = 522,
   parameter int W60_HI = 528,
   parameter int STREAK = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             field_end,
   input  logic             sync_taken,
   input  logic [CNT_W-1:0] end_cnt,
   input  logic             hold,
   output vstd_e            std_det
);
   localparam int RUN_W = $clog2(STREAK + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STREAK);
   localparam logic [CNT_W-1:0] L50 = CNT_W'(W50_LO);
   localparam logic [CNT_W-1:0] H50 = CNT_W'(W50_HI);
   localparam logic [CNT_W-1:0] L60 = CNT_W'(W60_LO);
   localparam logic [CNT_W-1:0] H60 = CNT_W'(W60_HI);

   vstd_e            cls;
   vstd_e            last_q;
   vstd_e            std_q;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_nx;

   always_comb begin
      if (!sync_taken)                            cls = STD_ODD;
      else if (end_cnt >= L50 && end_cnt <= H50)  cls = STD_50;
      else if (end_cnt >= L60 && end_cnt <= H60)  cls = STD_60;
      else                                        cls = STD_ODD;
   end

   always_comb begin
      if (cls != last_q)        run_nx = RUN_W'(1);
      else if (run_q == RUN_MAX) run_nx = run_q;
      else                      run_nx = run_q + RUN_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= STD_NONE;
         run_q  <= '0;
         std_q  <= STD_NONE;
      end else if (field_end && !hold) begin
         last_q <= cls;
         run_q  <= run_nx;
         if (run_nx == RUN_MAX) std_q <= cls;
      end
   end

   assign std_det = std_q;
endmodule

// File: rtl/vertical_countdown.sv
module vertical_countdown
   import vcd_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int W50_LO   = 622,
   parameter int W50_HI   = 628,
   parameter int W60_LO   = 522,
   parameter int W60_HI   = 528,
   parameter int WSR_LO   = 488,
   parameter int WSR_HI   = 722,
   parameter int STREAK   = 4,
   parameter int PULSE_HL = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hl_tick,
   input  logic       vsync_in,
   input  logic       line_locked,
   input  logic [1:0] ff_mode,
   input  logic       search_en,
   input  logic       ext_clamp,
   output logic       vpulse,
   output logic       vpulse_oe,
   output logic [1:0] std_det
);
   localparam int MAX_HI = (WSR_HI > W50_HI) ? ((WSR_HI > W60_HI) ? WSR_HI : W60_HI)
                                             : ((W50_HI > W60_HI) ? W50_HI : W60_HI);

   initial begin
      assert (W50_LO <= W50_HI && W60_LO <= W60_HI && WSR_LO <= WSR_HI)
         else $fatal(1, "window bounds out of order");
      assert (MAX_HI < (1 << CNT_W))
         else $fatal(1, "count width too small for the widest window");
      assert (PULSE_HL >= 1 && PULSE_HL < W60_LO && PULSE_HL < WSR_LO && PULSE_HL < W50_LO)
         else $fatal(1, "pulse must end before any window opens");
      assert (STREAK >= 1)
         else $fatal(1, "streak length must be positive");
   end

   logic [CNT_W-1:0] win_lo;
   logic [CNT_W-1:0] win_hi;
   logic             hold;
   logic             field_end;
   logic             sync_taken;
   logic [CNT_W-1:0] end_cnt;
   logic             pulse_raw;
   vstd_e            std_q;

   vcd_window_sel #(
      .CNT_W(CNT_W), .W50_LO(W50_LO), .W50_HI(W50_HI), .W60_LO(W60_LO),
      .W60_HI(W60_HI), .WSR_LO(WSR_LO), .WSR_HI(WSR_HI)
   ) u_win (
      .ff_mode(ff_mode), .line_locked(line_locked), .search_en(search_en),
      .std_det(std_q), .win_lo(win_lo), .win_hi(win_hi), .hold(hold)
   );

   vcd_halfline_ctr #(
      .CNT_W(CNT_W), .PULSE_HL(PULSE_HL)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .vsync_in(vsync_in),
      .win_lo(win_lo), .win_hi(win_hi), .field_end(field_end),
      .sync_taken(sync_taken), .end_cnt(end_cnt), .pulse_raw(pulse_raw)
   );

   vcd_std_tracker #(
      .CNT_W(CNT_W), .W50_LO(W50_LO), .W50_HI(W50_HI), .W60_LO(W60_LO),
      .W60_HI(W60_HI), .STREAK(STREAK)
   ) u_trk (
      .clk(clk), .rst_n(rst_n), .field_end(field_end), .sync_taken(sync_taken),
      .end_cnt(end_cnt), .hold(hold), .std_det(std_q)
   );

   assign vpulse    = pulse_raw && !ext_clamp;
   assign vpulse_oe = !ext_clamp;
   assign std_det   = std_q;
endmodule

// File: rtl/vcd_chk.sv
module vcd_chk #(
   parameter int CNT_W  = 10,
   parameter int W60_LO = 522,
   parameter int W60_HI = 528,
   parameter int WSR_LO = 488,
   parameter int WSR_HI = 722
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hl_tick,
   input logic             ext_clamp,
   input logic             search_en,
   input logic [1:0]       ff_mode,
   input logic             vpulse,
   input logic             vpulse_oe,
   input logic [1:0]       std_det,
   input logic [CNT_W-1:0] win_lo,
   input logic [CNT_W-1:0] win_hi,
   input logic             field_end
);
   localparam logic [CNT_W:0] GAP_MAX = (CNT_W+1)'(WSR_HI - 1);

   logic [CNT_W:0] gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             gap_cnt <= '0;
      else if (field_end)                     gap_cnt <= '0;
      else if (hl_tick && gap_cnt != '1)      gap_cnt <= gap_cnt + 1'b1;
   end

   // R4
   field_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap_cnt <= GAP_MAX);

   // R2
   pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hl_tick && !ext_clamp) |=> (ext_clamp || $stable(vpulse)));

   // R11
   clamp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_clamp |-> (!vpulse_oe && !vpulse));

   // R11
   drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_clamp |-> vpulse_oe);

   // R6
   std_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !field_end |=> $stable(std_det));

   // R9
   std_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ff_mode == 2'b10) |=> $stable(std_det));

   // R8
   force60_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ff_mode == 2'b01 && !search_en) |-> (win_lo == CNT_W'(W60_LO) && win_hi == CNT_W'(W60_HI)));

   // R10
   search_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      search_en |-> (win_lo == CNT_W'(WSR_LO) && win_hi == CNT_W'(WSR_HI)));
endmodule

bind vertical_countdown vcd_chk #(
   .CNT_W(CNT_W), .W60_LO(W60_LO), .W60_HI(W60_HI), .WSR_LO(WSR_LO), .WSR_HI(WSR_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .ext_clamp(ext_clamp),
   .search_en(search_en), .ff_mode(ff_mode), .vpulse(vpulse), .vpulse_oe(vpulse_oe),
   .std_det(std_det), .win_lo(win_lo), .win_hi(win_hi), .field_end(field_end)
);

// File: tb/vertical_countdown_tb.sv
module vertical_countdown_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hl_tick = 1'b0;
   logic       vsync_in = 1'b0;
   logic       line_locked = 1'b1;
   logic [1:0] ff_mode = 2'b11;
   logic       search_en = 1'b0;
   logic       ext_clamp = 1'b0;
   logic       vpulse;
   logic       vpulse_oe;
   logic [1:0] std_det;

   int    tests = 0;
   int    fails = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // reference model state
   int m_cnt = 0;
   bit m_act = 0;
   int m_run = 0;
   int m_cls = 0;
   int m_std = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vertical_countdown u_dut (
      .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .vsync_in(vsync_in),
      .line_locked(line_locked), .ff_mode(ff_mode), .search_en(search_en),
      .ext_clamp(ext_clamp), .vpulse(vpulse), .vpulse_oe(vpulse_oe), .std_det(std_det)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, advanced on every clock edge
   always @(posedge clk) begin
      int n, lo, hi, w, cls;
      bit acc, fin;
      if (!rst_n) begin
         m_cnt = 0; m_act = 0; m_run = 0; m_cls = 0; m_std = 0;
      end else if (hl_tick) begin
         n = m_cnt + 1;
         w = (m_std == 1) ? 50 : (m_std == 2) ? 60 : 0;
         if (ff_mode == 2'b01) w = 60;
         else if (ff_mode == 2'b00 && !line_locked) w = 60;
         else if (ff_mode == 2'b11 && !line_locked) w = 50;
         if (search_en) w = 0;
         lo = (w == 50) ? 622 : (w == 60) ? 522 : 488;
         hi = (w == 50) ? 628 : (w == 60) ? 528 : 722;
         acc = vsync_in && n >= lo && n <= hi;
         fin = acc || n >= hi;
         if (fin) begin
            if (!acc) cls = 3;
            else if (n >= 622 && n <= 628) cls = 1;
            else if (n >= 522 && n <= 528) cls = 2;
            else cls = 3;
            if (ff_mode != 2'b10) begin
               if (cls == m_cls) begin
                  if (m_run < 4) m_run++;
               end else begin
                  m_run = 1;
                  m_cls = cls;
               end
               if (m_run == 4) m_std = m_cls;
            end
            m_cnt = 0;
            m_act = 1;
         end else begin
            m_cnt = n;
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({cur_req, " pulse"}, int'(vpulse), int'(m_act && m_cnt < 6 && !ext_clamp));
         chk({cur_req, " oe"}, int'(vpulse_oe), int'(!ext_clamp));
         chk({cur_req, " std"}, int'(std_det), m_std);
      end
   end

   task automatic field(input int len, input int sync_at, input int gap = 1, input bit noise = 0);
      for (int i = 1; i <= len; i++) begin
         @(posedge clk); #2;
         hl_tick  = 1'b1;
         vsync_in = (i == sync_at);
         @(posedge clk); #2;
         hl_tick  = 1'b0;
         vsync_in = noise;
         for (int k = 1; k < gap; k++) begin
            @(posedge clk); #2;
         end
      end
      vsync_in = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 pulse", int'(vpulse), 0);
      chk("R1 oe", int'(vpulse_oe), 1);
      chk("R1 std", int'(std_det), 0);
      @(posedge clk); #2;
      rst_n = 1'b1;

      // detection of the 50 Hz standard through the search window
      cur_req = "R6";
      for (int f = 0; f < 3; f++) field(625, 625);
      @(negedge clk); chk("R6 before streak", int'(std_det), 0);
      field(625, 625);
      @(negedge clk); chk("R6 50Hz detected", int'(std_det), 1);

      // pulse width
      cur_req = "R2";
      field(5, 0);
      @(negedge clk); chk("R2 pulse tick5", int'(vpulse), 1);
      field(1, 0);
      @(negedge clk); chk("R2 pulse tick6", int'(vpulse), 0);
      field(619, 619);
      @(negedge clk); chk("R2 pulse start", int'(vpulse), 1);

      // window edges
      cur_req = "R5";
      field(622, 622);
      @(negedge clk); chk("R5 lower edge", int'(vpulse), 1);
      field(628, 628);
      @(negedge clk); chk("R5 upper edge", int'(vpulse), 1);

      cur_req = "R3";
      field(621, 621);
      @(negedge clk); chk("R3 early sync ignored", int'(vpulse), 0);
      cur_req = "R4";
      field(7, 0);
      @(negedge clk); chk("R4 self end at 628", int'(vpulse), 1);
      chk("R6 std kept", int'(std_det), 1);

      // sync on non-tick cycles
      cur_req = "R12";
      field(625, 625, 2, 1'b1);
      @(negedge clk); chk("R12 tick sync", int'(vpulse), 1);
      field(625, 0, 2, 1'b1);
      @(negedge clk); chk("R12 idle sync ignored", int'(vpulse), 0);
      field(3, 0, 2, 1'b0);

      // unlocked fallbacks
      cur_req = "R7";
      ff_mode = 2'b00; line_locked = 1'b0;
      field(525, 525);
      @(negedge clk); chk("R7 auto60 unlocked", int'(vpulse), 1);
      for (int f = 0; f < 3; f++) field(525, 525);
      @(negedge clk); chk("R7 60Hz detected", int'(std_det), 2);
      ff_mode = 2'b11;
      field(625, 625);
      @(negedge clk); chk("R7 auto50 unlocked", int'(vpulse), 1);

      // hold mode
      cur_req = "R9";
      ff_mode = 2'b10; line_locked = 1'b1;
      for (int f = 0; f < 4; f++) begin
         field(528, 0);
         @(negedge clk); chk("R9 held 60 window", int'(vpulse), 1);
      end
      chk("R9 std frozen", int'(std_det), 2);

      // forced 60 taking effect mid-field
      cur_req = "R8";
      ff_mode = 2'b11; line_locked = 1'b0;
      field(300, 0);
      ff_mode = 2'b01;
      field(227, 0);
      @(negedge clk); chk("R8 before edge", int'(vpulse), 0);
      field(1, 0);
      @(negedge clk); chk("R8 forced 60 end", int'(vpulse), 1);

      // search override
      cur_req = "R10";
      search_en = 1'b1;
      field(700, 700);
      @(negedge clk); chk("R10 sync at 700", int'(vpulse), 1);
      field(721, 0);
      @(negedge clk); chk("R10 open at 721", int'(vpulse), 0);
      field(1, 0);
      @(negedge clk); chk("R10 self end 722", int'(vpulse), 1);
      field(490, 490);
      @(negedge clk); chk("R10 sync at 490", int'(vpulse), 1);
      chk("R6 nonstandard detected", int'(std_det), 3);

      // external clamp
      cur_req = "R11";
      search_en = 1'b0; ff_mode = 2'b11; line_locked = 1'b1;
      ext_clamp = 1'b1;
      field(625, 625);
      @(negedge clk);
      chk("R11 pulse low", int'(vpulse), 0);
      chk("R11 oe low", int'(vpulse_oe), 0);
      @(posedge clk); #2;
      ext_clamp = 1'b0;
      @(negedge clk);
      chk("R11 pulse back", int'(vpulse), 1);
      chk("R11 oe back", int'(vpulse_oe), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule